// File: doc/BRIEF.md
# Command Queue with Status Word

This block sits between a host bus and a set of drawing engines. The host writes commands: each is a register address plus 32 bits of data. Writes that fall inside the command window are queued in a first-in first-out buffer. The engines drain that buffer through a show-ahead consumer port. A single 32-bit status word is readable at one fixed address. It gives the host three things: how much room is left in the queue, whether the two downstream units are busy, and two sticky error flags.

The host uses the status word for flow control. It reads the free-entry count and holds back eight entries as headroom. It only writes more commands after checking the count again. An error flag stays set until the host writes a one to its bit at the status address; a zero leaves the flag as it is. A separate idle output is high when both downstream units are quiet and no command is waiting.

Top module: `cmdq_status`

## Requirements
- R1: After a synchronous active-high reset the queue is empty, `cmd_valid` is 0, both error flags are 0, and a status read returns a free count of DEPTH in bits 11:0.
- R2: Status bits 11:0 hold DEPTH minus the number of queued commands. The count changes on the clock edge that accepts a push or a pop and never exceeds DEPTH.
- R3: A host write to an address below CMD_LIMIT queues {address, data}. Commands leave in write order with both fields intact. The head entry is shown on `cmd_addr`/`cmd_data` while `cmd_valid` is 1, and it is removed on a clock edge where `cmd_pop` is 1.
- R4: A command write while the queue holds DEPTH entries is dropped, even if a pop happens in the same cycle, and it sets the sticky overflow flag in status bit 31.
- R5: The sticky read-error flag in status bit 30 is set by any of these:
  - a status read while `rdback_pending` is 1;
  - a read of any address other than STATUS_ADDR, which returns data 0;
  - a write to an address that is neither in the command window nor STATUS_ADDR.
- R6: A write to STATUS_ADDR is not queued. A one in data bit 31 clears the overflow flag, a one in bit 30 clears the read-error flag, and a zero leaves the flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: Status bit 24 reports `fb_busy` and bit 25 reports `rp_busy`, as sampled in the cycle of the read. Bits 23:12 and 29:26 read as 0.
- R8: `engine_idle` is 1 exactly when `fb_busy` and `rp_busy` are both 0 and the queue is empty.
- R9: With no pops, a host that reads a free count F and then writes F minus 8 commands leaves the overflow flag clear, and a following status read reports a free count of 8.
- R10: `host_rd_valid` is 1 in the cycle after a cycle with `host_rd_en` high, and 0 otherwise. `host_rd_data` then holds the status as it was before that read cycle's own pushes, pops and flag updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | AW | Host write address |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | AW | Host read address |
| rdback_pending | input | 1 | A register read-back is still outstanding |
| host_rd_valid | output | 1 | Read data valid (one cycle after the strobe) |
| host_rd_data | output | 32 | Read data |
| fb_busy | input | 1 | Frame-buffer unit busy |
| rp_busy | input | 1 | Raster unit busy |
| cmd_valid | output | 1 | Queue head is valid |
| cmd_addr | output | AW | Head command address |
| cmd_data | output | 32 | Head command data |
| cmd_pop | input | 1 | Consumer removes the head entry |
| engine_idle | output | 1 | Both units idle and queue empty |

## Verification
The hardest case to reach is the full-queue boundary: a command write that arrives together with a consumer pop, and an error flag that is cleared and set again in the same cycle. The stimulus first fills the queue with the consumer stalled. It then issues extra writes, both with and without a concurrent pop. It also pairs a status write that clears the flags with an unmapped read in the same cycle. A long pseudo-random phase then mixes all access kinds, busy levels and pops. A behavioural queue model is compared against the outputs on every clock.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int STAT_W      = 32;
    localparam int FREE_W      = 12;
    localparam int FB_BUSY_BIT = 24;
    localparam int RP_BUSY_BIT = 25;
    localparam int RDERR_BIT   = 30;
    localparam int OVF_BIT     = 31;

    // Classification of one host access
    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_CMD      = 2'd1,
        ACC_STATUS   = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic ovf;
        logic rderr;
    } err_flags_t;

    typedef struct packed {
        logic ovf;
        logic rderr;
    } err_evt_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [FREE_W-1:0] free_cnt,
        input logic              fb,
        input logic              rp,
        input err_flags_t        flags
    );
        logic [STAT_W-1:0] w;
        w                = '0;
        w[FREE_W-1:0]    = free_cnt;
        w[FB_BUSY_BIT]   = fb;
        w[RP_BUSY_BIT]   = rp;
        w[RDERR_BIT]     = flags.rderr;
        w[OVF_BIT]       = flags.ovf;
        return w;
    endfunction

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int             AW          = 8,
    parameter logic [AW-1:0]  CMD_LIMIT   = AW'(128),
    parameter logic [AW-1:0]  STATUS_ADDR = AW'(252)
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rdback_pending,
    output acc_kind_e     wr_kind,
    output acc_kind_e     rd_kind,
    output logic          rderr_evt
);

    function automatic acc_kind_e classify(input logic en, input logic [AW-1:0] a);
        if (!en)                  return ACC_NONE;
        if (a == STATUS_ADDR)     return ACC_STATUS;
        if (a < CMD_LIMIT)        return ACC_CMD;
        return ACC_UNMAPPED;
    endfunction

    always_comb begin
        wr_kind = classify(wr_en, wr_addr);
        // the command window is write-only: any read except status is unmapped
        if (!rd_en)                      rd_kind = ACC_NONE;
        else if (rd_addr == STATUS_ADDR) rd_kind = ACC_STATUS;
        else                             rd_kind = ACC_UNMAPPED;
    end

    always_comb begin
        rderr_evt = 1'b0;
        if (wr_kind == ACC_UNMAPPED)                        rderr_evt = 1'b1;
        if (rd_kind == ACC_UNMAPPED)                        rderr_evt = 1'b1;
        if ((rd_kind == ACC_STATUS) && rdback_pending)      rderr_evt = 1'b1;
    end

endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 40,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             valid,
    output logic             full,
    output logic [OCC_W-1:0] occ
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (occ == OCC_W'(DEPTH));
    assign valid   = (occ != '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && valid;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/cmdq_errflags.sv
module cmdq_errflags
    import cmdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_evt_t   set_evt,
    input  err_evt_t   clr_evt,
    output err_flags_t flags
);

    // a set in the same cycle as a clear wins, so no event is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.ovf   <= set_evt.ovf   | (flags.ovf   & ~clr_evt.ovf);
            flags.rderr <= set_evt.rderr | (flags.rderr & ~clr_evt.rderr);
        end
    end

endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
    import cmdq_pkg::*;
#(
    parameter int             AW          = 8,
    parameter int             DEPTH       = 16,   // at most 4095 (12-bit free count)
    parameter logic [AW-1:0]  CMD_LIMIT   = AW'(128),
    parameter logic [AW-1:0]  STATUS_ADDR = AW'(252)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [31:0]   host_wr_data,
    input  logic          host_rd_en,
    input  logic [AW-1:0] host_rd_addr,
    input  logic          rdback_pending,
    output logic          host_rd_valid,
    output logic [31:0]   host_rd_data,
    input  logic          fb_busy,
    input  logic          rp_busy,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [31:0]   cmd_data,
    input  logic          cmd_pop,
    output logic          engine_idle
);

    localparam int ENT_W = AW + 32;
    localparam int OCC_W = $clog2(DEPTH + 1);

    acc_kind_e          wr_kind, rd_kind;
    logic               rderr_evt;
    logic               q_full;
    logic [OCC_W-1:0]   q_occ;
    logic [ENT_W-1:0]   q_head;
    logic [FREE_W-1:0]  free_cnt;
    err_evt_t           set_evt, clr_evt;
    err_flags_t         flags;
    logic [STAT_W-1:0]  status_w;
    logic               rd_valid_q;
    logic [31:0]        rd_data_q;

    cmdq_decode #(
        .AW(AW), .CMD_LIMIT(CMD_LIMIT), .STATUS_ADDR(STATUS_ADDR)
    ) u_dec (
        .wr_en(host_wr_en), .wr_addr(host_wr_addr),
        .rd_en(host_rd_en), .rd_addr(host_rd_addr),
        .rdback_pending(rdback_pending),
        .wr_kind(wr_kind), .rd_kind(rd_kind), .rderr_evt(rderr_evt)
    );

    cmdq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(wr_kind == ACC_CMD),
        .din({host_wr_addr, host_wr_data}),
        .pop(cmd_pop),
        .dout(q_head), .valid(cmd_valid), .full(q_full), .occ(q_occ)
    );

    always_comb begin
        set_evt.ovf   = (wr_kind == ACC_CMD) && q_full;
        set_evt.rderr = rderr_evt;
        clr_evt.ovf   = (wr_kind == ACC_STATUS) && host_wr_data[OVF_BIT];
        clr_evt.rderr = (wr_kind == ACC_STATUS) && host_wr_data[RDERR_BIT];
    end

    cmdq_errflags u_err (
        .clk(clk), .rst(rst),
        .set_evt(set_evt), .clr_evt(clr_evt), .flags(flags)
    );

    assign free_cnt = FREE_W'(DEPTH) - FREE_W'(q_occ);
    assign status_w = pack_status(free_cnt, fb_busy, rp_busy, flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= host_rd_en;
            rd_data_q  <= (rd_kind == ACC_STATUS) ? status_w : '0;
        end
    end

    assign host_rd_valid = rd_valid_q;
    assign host_rd_data  = rd_data_q;
    assign cmd_addr      = q_head[ENT_W-1 -: AW];
    assign cmd_data      = q_head[31:0];
    assign engine_idle   = !fb_busy && !rp_busy && (q_occ == '0);

endmodule

// File: rtl/cmdq_status_chk.sv
module cmdq_status_chk #(
    parameter int             AW          = 8,
    parameter int             DEPTH       = 16,
    parameter logic [AW-1:0]  CMD_LIMIT   = AW'(128),
    parameter logic [AW-1:0]  STATUS_ADDR = AW'(252),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr_en,
    input logic [AW-1:0]    host_wr_addr,
    input logic [31:0]      host_wr_data,
    input logic             host_rd_en,
    input logic [AW-1:0]    host_rd_addr,
    input logic             host_rd_valid,
    input logic [31:0]      host_rd_data,
    input logic             cmd_valid,
    input logic             cmd_pop,
    input logic [AW-1:0]    cmd_addr,
    input logic [31:0]      cmd_data,
    input logic             engine_idle,
    input logic [OCC_W-1:0] occ,
    input logic             full,
    input logic             flag_ovf,
    input logic             flag_rderr
);

    logic wr_cmd;
    assign wr_cmd = host_wr_en && (host_wr_addr < CMD_LIMIT);

    // R4
    overflow_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && full) |=> flag_ovf);

    // R4
    dropped_write_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && full && !(cmd_pop && cmd_valid)) |=> (occ == $past(occ)));

    // R2
    occ_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ == $past(occ) - 1'b1)));

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_pop && !full) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

    // R5
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && (host_rd_addr != STATUS_ADDR)) |=> (flag_rderr && (host_rd_data == '0)));

    // R6
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && (host_wr_addr == STATUS_ADDR) && host_wr_data[31]) |=> !flag_ovf);

    // R10
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd_en |=> host_rd_valid);

    // R10
    rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en |=> !host_rd_valid);

    // R8
    idle_means_empty_chk: assert property (@(posedge clk) disable iff (rst)
        engine_idle |-> !cmd_valid);

endmodule

bind cmdq_status cmdq_status_chk #(
    .AW(AW), .DEPTH(DEPTH), .CMD_LIMIT(CMD_LIMIT), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
    .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .engine_idle(engine_idle), .occ(q_occ), .full(q_full),
    .flag_ovf(flags.ovf), .flag_rderr(flags.rderr)
);

// File: tb/test_cmdq_status.sv
module test_cmdq_status;

    localparam int            AW    = 8;
    localparam int            DEPTH = 16;
    localparam logic [AW-1:0] LIM   = 8'h80;
    localparam logic [AW-1:0] ST    = 8'hFC;
    localparam logic [AW-1:0] UNM   = 8'h90;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [31:0]   host_wr_data = '0;
    logic          host_rd_en = 1'b0;
    logic [AW-1:0] host_rd_addr = '0;
    logic          rdback_pending = 1'b0;
    logic          host_rd_valid;
    logic [31:0]   host_rd_data;
    logic          fb_busy = 1'b0;
    logic          rp_busy = 1'b0;
    logic          cmd_valid;
    logic [AW-1:0] cmd_addr;
    logic [31:0]   cmd_data;
    logic          cmd_pop = 1'b0;
    logic          engine_idle;

    cmdq_status #(.AW(AW), .DEPTH(DEPTH), .CMD_LIMIT(LIM), .STATUS_ADDR(ST)) i_cmdq_status (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
        .rdback_pending(rdback_pending),
        .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
        .fb_busy(fb_busy), .rp_busy(rp_busy),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_pop(cmd_pop), .engine_idle(engine_idle)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R1";

    // reference model
    logic [AW+31:0] q[$];
    bit             m_ovf, m_rerr, m_rd_valid;
    logic [31:0]    m_rd_data;

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", t, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s        = '0;
        s[11:0]  = 12'(DEPTH - q.size());
        s[24]    = fb_busy;
        s[25]    = rp_busy;
        s[30]    = m_rerr;
        s[31]    = m_ovf;
        return s;
    endfunction

    task automatic model_step();
        logic [31:0] st;
        bit          was_full, set_o, set_r;
        if (rst) begin
            q.delete();
            m_ovf = 0; m_rerr = 0; m_rd_valid = 0; m_rd_data = '0;
            return;
        end
        st       = m_status();
        was_full = (q.size() == DEPTH);
        m_rd_valid = host_rd_en;
        m_rd_data  = (host_rd_en && host_rd_addr == ST) ? st : 32'h0;
        set_o = host_wr_en && (host_wr_addr < LIM) && was_full;
        set_r = (host_rd_en && (host_rd_addr != ST || rdback_pending)) ||
                (host_wr_en && host_wr_addr >= LIM && host_wr_addr != ST);
        if (cmd_pop && q.size() > 0) void'(q.pop_front());
        if (host_wr_en && host_wr_addr < LIM && !was_full) q.push_back({host_wr_addr, host_wr_data});
        if (host_wr_en && host_wr_addr == ST) begin
            if (host_wr_data[31]) m_ovf  = 0;
            if (host_wr_data[30]) m_rerr = 0;
        end
        if (set_o) m_ovf  = 1;
        if (set_r) m_rerr = 1;
    endtask

    task automatic compare();
        bit mv;
        mv = (q.size() > 0);
        chk(cmd_valid === mv, "R3", "cmd_valid", 64'(cmd_valid), 64'(mv));
        if (mv) chk({cmd_addr, cmd_data} === q[0], "R3", "head entry",
                    64'({cmd_addr, cmd_data}), 64'(q[0]));
        chk(engine_idle === (!mv && !fb_busy && !rp_busy), "R8", "engine_idle",
            64'(engine_idle), 64'(!mv && !fb_busy && !rp_busy));
        chk(host_rd_valid === m_rd_valid, "R10", "rd_valid", 64'(host_rd_valid), 64'(m_rd_valid));
        if (m_rd_valid) chk(host_rd_data === m_rd_data, tag, "rd_data",
                            64'(host_rd_data), 64'(m_rd_data));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        host_wr_en = 1; host_wr_addr = a; host_wr_data = d;
        tick();
        host_wr_en = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        host_rd_en = 1; host_rd_addr = a;
        tick();
        host_rd_en = 0;
    endtask

    task automatic drain();
        cmd_pop = 1;
        while (cmd_valid) tick();
        cmd_pop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog expired actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        int          freec;
        lfsr = 32'h1234_5678;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;

        // R1: reset state
        tag = "R1";
        chk(cmd_valid == 0, "R1", "cmd_valid after reset", 64'(cmd_valid), 0);
        rd(ST);
        chk(host_rd_data == 32'(DEPTH), "R1", "status after reset", 64'(host_rd_data), 64'(DEPTH));

        // R2: free count tracks pushes
        tag = "R2";
        for (int i = 0; i < 3; i++) wr(AW'(i + 4), 32'hA000_0000 + 32'(i));
        rd(ST);
        chk(host_rd_data[11:0] == 12'(DEPTH - 3), "R2", "free after 3 pushes",
            64'(host_rd_data[11:0]), 64'(DEPTH - 3));

        // R3: order on drain
        tag = "R3";
        drain();
        rd(ST);

        // R4: overflow, including with concurrent pop
        tag = "R4";
        for (int i = 0; i < DEPTH; i++) wr(AW'(i), 32'hC0DE_0000 + 32'(i));
        wr(8'h11, 32'hDEAD_0001);
        rd(ST);
        chk(host_rd_data[31] == 1'b1, "R4", "overflow flag", 64'(host_rd_data[31]), 1);
        chk(host_rd_data[11:0] == 12'd0, "R4", "free when full", 64'(host_rd_data[11:0]), 0);
        cmd_pop = 1;
        wr(8'h12, 32'hDEAD_0002);
        cmd_pop = 0;
        rd(ST);

        // R6: write-one-to-clear, zero bits keep, set wins
        tag = "R6";
        rd(UNM);
        wr(ST, 32'h0000_0000);
        rd(ST);
        chk(host_rd_data[31:30] == 2'b11, "R6", "zeros keep flags", 64'(host_rd_data[31:30]), 3);
        wr(ST, 32'h8000_0000);
        rd(ST);
        chk(host_rd_data[31:30] == 2'b01, "R6", "clear ovf only", 64'(host_rd_data[31:30]), 1);
        host_rd_en = 1; host_rd_addr = UNM;
        wr(ST, 32'h4000_0000);
        host_rd_en = 0;
        rd(ST);
        chk(host_rd_data[30] == 1'b1, "R6", "set wins over clear", 64'(host_rd_data[30]), 1);
        wr(ST, 32'hC000_0000);
        rd(ST);
        chk(host_rd_data[31:30] == 2'b00, "R6", "both cleared", 64'(host_rd_data[31:30]), 0);

        // R5: read-error sources
        tag = "R5";
        rdback_pending = 1;
        rd(ST);
        rdback_pending = 0;
        rd(ST);
        chk(host_rd_data[30] == 1'b1, "R5", "pending read err", 64'(host_rd_data[30]), 1);
        wr(ST, 32'h4000_0000);
        wr(UNM, 32'h5555_5555);
        rd(ST);
        chk(host_rd_data[30] == 1'b1, "R5", "unmapped write err", 64'(host_rd_data[30]), 1);
        wr(ST, 32'h4000_0000);
        rd(8'h10);
        chk(host_rd_data == 32'h0, "R5", "unmapped read data", 64'(host_rd_data), 0);

        // R7: busy bits
        tag = "R7";
        fb_busy = 1; rd(ST);
        chk(host_rd_data[25:24] == 2'b01, "R7", "fb busy", 64'(host_rd_data[25:24]), 1);
        fb_busy = 0; rp_busy = 1; rd(ST);
        chk(host_rd_data[25:24] == 2'b10, "R7", "rp busy", 64'(host_rd_data[25:24]), 2);
        fb_busy = 1; rd(ST);
        fb_busy = 0; rp_busy = 0;

        // R8: idle only with empty queue and no busy
        tag = "R8";
        drain();
        chk(engine_idle == 1'b1, "R8", "idle when quiet", 64'(engine_idle), 1);
        fb_busy = 1; tick();
        chk(engine_idle == 1'b0, "R8", "busy blocks idle", 64'(engine_idle), 0);
        fb_busy = 0; wr(8'h01, 32'h1);
        chk(engine_idle == 1'b0, "R8", "queued cmd blocks idle", 64'(engine_idle), 0);
        drain();

        // R9: headroom discipline
        tag = "R9";
        wr(ST, 32'hC000_0000);
        rd(ST);
        freec = int'(host_rd_data[11:0]);
        for (int i = 0; i < freec - 8; i++) wr(AW'(i), 32'(i));
        rd(ST);
        chk(host_rd_data[31] == 1'b0, "R9", "no overflow", 64'(host_rd_data[31]), 0);
        chk(host_rd_data[11:0] == 12'd8, "R9", "headroom left", 64'(host_rd_data[11:0]), 8);
        drain();

        // R10: back-to-back reads during pushes
        tag = "R10";
        host_rd_en = 1; host_rd_addr = ST;
        for (int i = 0; i < 5; i++) wr(AW'(i), 32'hB0B0_0000 + 32'(i));
        host_rd_en = 0;
        tick();
        drain();

        // mixed random traffic
        tag = "R3";
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            host_wr_en     = lfsr[31] | lfsr[30];
            host_wr_addr   = (lfsr[29:28] == 2'b00) ? ST : (lfsr[29:28] == 2'b01 && lfsr[3]) ? UNM : {1'b0, lfsr[10:4]};
            host_wr_data   = {lfsr[27:26], lfsr[25:0] ^ 26'h2AA_AAAA, 4'h0};
            host_rd_en     = lfsr[24];
            host_rd_addr   = lfsr[23:21] == 3'b000 ? UNM : ST;
            rdback_pending = lfsr[20] & lfsr[19];
            fb_busy        = lfsr[18];
            rp_busy        = lfsr[17] & lfsr[16];
            cmd_pop        = (n % 200 < 100) ? (lfsr[15] & lfsr[14] & lfsr[13]) : lfsr[15];
            tick();
        end
        host_wr_en = 0; host_rd_en = 0; rdback_pending = 0;
        fb_busy = 0; rp_busy = 0; cmd_pop = 0;
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule